// File: doc/BRIEF.md
# Cross-Track Parity Byte Corrector

This block sits on a group of bit-serial tracks: several data tracks plus one track that carries their even cross-track parity. Every track moves in 9-bit units. A shared strobe marks the first bit of each unit, which is an error flag; the eight data bits follow in the next eight cycles. The flag arrives before the data, so the block decides at the flag bit whether the byte can be repaired. That decision then holds while the data bits stream through.

When correction is switched on and exactly one track of the group flags its byte, the block clears that flag and regenerates the track's eight bits from the XOR of all the other tracks. With no flag, or with two or more flags, the byte goes out unchanged with its flags. With correction switched off the block is a plain one-cycle delay. Two saturating counters record repaired bytes and byte slots that had too many flags to repair.

Top module: `xtrack_fix`

## Requirements
- R1: While reset is active and right after it, `trk_out`, `fixed_cnt` and `lost_cnt` are all zero.
- R2: `trk_out` equals `trk_in` of the previous cycle whenever no repair is in progress. This covers a flag slot with no flag set, and it holds with a delay of exactly one cycle.
- R3: If `fix_en` is 1 in a `byte_start` cycle and exactly one data track (bits 0 to DATA_TRACKS-1) shows a 1 flag, the output flag row one cycle later is all zero. During the following BYTE_BITS output cycles that track carries the XOR of all the other tracks' bits in each cycle. All other tracks pass unchanged.
- R4: The same repair applies when the single flagged track is the parity track (bit DATA_TRACKS).
- R5: If two or more flags are set in a `byte_start` cycle, the flag row and all data bits of that byte pass unchanged, and `lost_cnt` increments by one when `fix_en` is 1.
- R6: If `fix_en` is 0 in the `byte_start` cycle, the byte passes unchanged even when exactly one flag is set, and neither counter moves. `fix_en` is only sampled in `byte_start` cycles.
- R7: `fixed_cnt` increments by exactly one for each repaired byte. Both counters change only in the cycle in which the flag row of their byte appears on `trk_out`.
- R8: A repair lasts for exactly BYTE_BITS cycles after its flag slot. Bits that arrive later without a new `byte_start` pass unchanged.
- R9: Both counters saturate at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fix_en | input | 1 | 1 selects cross-track repair; 0 selects pass-through |
| byte_start | input | 1 | Marks the cycle in which `trk_in` holds the flag row |
| trk_in | input | DATA_TRACKS+1 | One bit per track; the MSB is the parity track |
| trk_out | output | DATA_TRACKS+1 | Repaired streams, one cycle behind `trk_in` |
| fixed_cnt | output | CNT_W | Saturating count of repaired bytes |
| lost_cnt | output | CNT_W | Saturating count of byte slots with two or more flags |

## Verification
The properties assume that `byte_start` marks a genuine flag row and that the data tracks satisfy even parity with the parity track. Only under that assumption is a regenerated byte the byte that was originally sent. The stimulus builds every byte from clean data, computes the parity track, and only then garbles the flagged tracks with a nonzero mask. The bench can therefore predict the repaired output as the clean original. `byte_start` is raised only at unit boundaries or in deliberate idle stretches, so no flag row is ever mistaken for data.

// File: rtl/xtrack_pkg.sv
package xtrack_pkg;
  typedef enum logic [1:0] {
    VD_CLEAN = 2'd0,
    VD_FIX   = 2'd1,
    VD_LOST  = 2'd2
  } verdict_e;
endpackage

// File: rtl/xtrack_flag_judge.sv
module xtrack_flag_judge
  import xtrack_pkg::*;
#(
  parameter int N_TRK = 9
) (
  input  logic [N_TRK-1:0] flags,
  input  logic             fix_en,
  output verdict_e         verdict,
  output logic [N_TRK-1:0] fix_mask
);
  localparam int CW = $clog2(N_TRK + 1);

  logic [CW-1:0] flag_cnt;

  always_comb begin
    flag_cnt = '0;
    for (int i = 0; i < N_TRK; i++) begin
      flag_cnt = flag_cnt + CW'(flags[i]);
    end
  end

  always_comb begin
    if (!fix_en)                 verdict = VD_CLEAN;
    else if (flag_cnt == CW'(1)) verdict = VD_FIX;
    else if (flag_cnt != '0)     verdict = VD_LOST;
    else                         verdict = VD_CLEAN;
    fix_mask = (verdict == VD_FIX) ? flags : '0;
  end
endmodule

// File: rtl/xtrack_bit_rebuild.sv
module xtrack_bit_rebuild #(
  parameter int N_TRK = 9
) (
  input  logic [N_TRK-1:0] bits,
  output logic [N_TRK-1:0] rebuilt
);
  logic syndrome;

  assign syndrome = ^bits;

  // removing a track's own bit from the total XOR leaves the XOR of the others
  for (genvar g = 0; g < N_TRK; g++) begin : g_trk
    assign rebuilt[g] = syndrome ^ bits[g];
  end
endmodule

// File: rtl/xtrack_sat_ctr.sv
module xtrack_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = inc && (cnt != '1);
    cnt_d  = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/xtrack_fix.sv
module xtrack_fix
  import xtrack_pkg::*;
#(
  parameter int DATA_TRACKS = 8,
  parameter int BYTE_BITS   = 8,
  parameter int CNT_W       = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fix_en,
  input  logic                   byte_start,
  input  logic [DATA_TRACKS:0]   trk_in,
  output logic [DATA_TRACKS:0]   trk_out,
  output logic [CNT_W-1:0]       fixed_cnt,
  output logic [CNT_W-1:0]       lost_cnt
);
  localparam int N_TRK = DATA_TRACKS + 1;
  localparam int WIN_W = $clog2(BYTE_BITS + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  verdict_e         verdict;
  logic [N_TRK-1:0] fix_mask;
  logic [N_TRK-1:0] rebuilt;

  xtrack_flag_judge #(.N_TRK(N_TRK)) u_judge (
    .flags    (trk_in),
    .fix_en   (fix_en),
    .verdict  (verdict),
    .fix_mask (fix_mask)
  );

  xtrack_bit_rebuild #(.N_TRK(N_TRK)) u_rebuild (
    .bits    (trk_in),
    .rebuilt (rebuilt)
  );

  // repair window state
  logic [WIN_W-1:0] win_cnt_q, win_cnt_d;
  logic [N_TRK-1:0] hold_mask_q, hold_mask_d;
  logic             win_en, win_active;
  logic [N_TRK-1:0] out_d;

  always_comb begin
    win_cnt_d   = win_cnt_q;
    hold_mask_d = hold_mask_q;
    win_en      = byte_start || (win_cnt_q != '0);
    win_active  = (win_cnt_q != '0) && !byte_start;
    if (byte_start) begin
      win_cnt_d   = WIN_W'(BYTE_BITS);
      hold_mask_d = fix_mask;
    end else if (win_cnt_q != '0) begin
      win_cnt_d = win_cnt_q - WIN_W'(1);
      if (win_cnt_q == WIN_W'(1)) hold_mask_d = '0;
    end
  end

  always_comb begin
    if (byte_start)
      out_d = trk_in & ~fix_mask;
    else if (win_active)
      out_d = (trk_in & ~hold_mask_q) | (rebuilt & hold_mask_q);
    else
      out_d = trk_in;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      win_cnt_q   <= '0;
      hold_mask_q <= '0;
    end else if (win_en) begin
      win_cnt_q   <= win_cnt_d;
      hold_mask_q <= hold_mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) trk_out <= '0;
    else            trk_out <= out_d;
  end

  logic inc_fix, inc_lost;
  assign inc_fix  = byte_start && (verdict == VD_FIX);
  assign inc_lost = byte_start && (verdict == VD_LOST);

  xtrack_sat_ctr #(.W(CNT_W)) u_fix_ctr (
    .clk (clk), .rst_n (rst_int_n), .inc (inc_fix), .cnt (fixed_cnt)
  );

  xtrack_sat_ctr #(.W(CNT_W)) u_lost_ctr (
    .clk (clk), .rst_n (rst_int_n), .inc (inc_lost), .cnt (lost_cnt)
  );
endmodule

// File: rtl/xtrack_fix_chk.sv
module xtrack_fix_chk #(
  parameter int DATA_TRACKS = 8,
  parameter int CNT_W       = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fix_en,
  input logic                 byte_start,
  input logic [DATA_TRACKS:0] trk_in,
  input logic [DATA_TRACKS:0] trk_out,
  input logic [CNT_W-1:0]     fixed_cnt,
  input logic [CNT_W-1:0]     lost_cnt
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(byte_start) && !$past(fix_en) |-> trk_out == $past(trk_in)); // R6

  AST_SINGLE_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(byte_start) && $past(fix_en) && ($countones($past(trk_in)) == 1)
    |-> trk_out == '0); // R3

  AST_MULTI_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(byte_start) && ($countones($past(trk_in)) > 1)
    |-> trk_out == $past(trk_in)); // R5

  AST_FIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (fixed_cnt == $past(fixed_cnt)) || (fixed_cnt == $past(fixed_cnt) + CNT_W'(1))); // R7

  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(byte_start) |-> $stable(fixed_cnt) && $stable(lost_cnt)); // R7

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ($past(fixed_cnt) == '1) |-> fixed_cnt == '1); // R9
endmodule

bind xtrack_fix xtrack_fix_chk #(.DATA_TRACKS(DATA_TRACKS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fix_en     (fix_en),
  .byte_start (byte_start),
  .trk_in     (trk_in),
  .trk_out    (trk_out),
  .fixed_cnt  (fixed_cnt),
  .lost_cnt   (lost_cnt)
);

// File: tb/test_xtrack_fix.sv
module test_xtrack_fix;
  localparam int CLK_PERIOD = 10;
  localparam int DT = 8;
  localparam int BB = 8;
  localparam int CW = 4;
  localparam logic [CW-1:0] CMAX = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fix_en;
  logic          byte_start;
  logic [DT:0]   trk_in;
  logic [DT:0]   trk_out;
  logic [CW-1:0] fixed_cnt, lost_cnt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xtrack_fix #(.DATA_TRACKS(DT), .BYTE_BITS(BB), .CNT_W(CW)) i_xtrack_fix (
    .clk(clk), .rst_n(rst_n), .fix_en(fix_en), .byte_start(byte_start),
    .trk_in(trk_in), .trk_out(trk_out), .fixed_cnt(fixed_cnt), .lost_cnt(lost_cnt)
  );

  int total = 0;
  int bad   = 0;
  logic [CW-1:0] exp_fx = '0, exp_lx = '0;

  logic [DT:0]   q_trk[$];
  logic [CW-1:0] q_fx[$], q_lx[$];
  string         q_tag[$];

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic step(input logic [DT:0] v, input logic bs, input logic en,
                      input string tag, input logic [DT:0] exp_v);
    @(negedge clk);
    trk_in = v; byte_start = bs; fix_en = en;
    q_trk.push_back(exp_v); q_fx.push_back(exp_fx); q_lx.push_back(exp_lx);
    q_tag.push_back(tag);
  endtask

  task automatic send_byte(input logic [DT-1:0][7:0] dat, input logic [DT:0] flg,
                           input logic en, input logic [7:0] garble, input string tag);
    logic [DT:0][7:0] good, corrupt;
    logic [7:0] par;
    logic repair;
    logic [DT:0] v, e;
    par = '0;
    for (int t = 0; t < DT; t++) begin good[t] = dat[t]; par ^= dat[t]; end
    good[DT] = par;
    for (int t = 0; t <= DT; t++) corrupt[t] = flg[t] ? (good[t] ^ garble) : good[t];
    repair = en && ($countones(flg) == 1);
    if (repair && exp_fx != CMAX) exp_fx = exp_fx + 1'b1;
    if (en && ($countones(flg) > 1) && exp_lx != CMAX) exp_lx = exp_lx + 1'b1;
    step(flg, 1'b1, en, tag, repair ? '0 : flg);
    for (int k = 0; k < BB; k++) begin
      for (int t = 0; t <= DT; t++) begin
        v[t] = corrupt[t][7-k];
        e[t] = repair ? good[t][7-k] : corrupt[t][7-k];
      end
      step(v, 1'b0, en, tag, e);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step('0, 1'b0, 1'b0, tag, '0);
  endtask

  // monitor: one expected item per cycle, compared a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD / 4);
      if (q_trk.size() > 0) begin
        logic [DT:0] et; logic [CW-1:0] ef, el; string tg;
        et = q_trk.pop_front(); ef = q_fx.pop_front(); el = q_lx.pop_front();
        tg = q_tag.pop_front();
        total++;
        if (trk_out !== et) begin
          bad++; $display("FAIL %s trk_out act=%h exp=%h", tg, trk_out, et);
        end
        total++;
        if (fixed_cnt !== ef || lost_cnt !== el) begin
          bad++;
          $display("FAIL %s counters act=%0d/%0d exp=%0d/%0d", tg, fixed_cnt, lost_cnt, ef, el);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    report();
  end

  initial begin
    logic [DT-1:0][7:0] d;
    rst_n = 1'b0; fix_en = 1'b0; byte_start = 1'b0; trk_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    total++;
    if (trk_out !== '0 || fixed_cnt !== '0 || lost_cnt !== '0) begin
      bad++; $display("FAIL R1 act=%h/%0d/%0d exp=0/0/0", trk_out, fixed_cnt, lost_cnt);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    total++;
    if (trk_out !== '0 || fixed_cnt !== '0 || lost_cnt !== '0) begin
      bad++; $display("FAIL R1 after release act=%h/%0d/%0d exp=0/0/0", trk_out, fixed_cnt, lost_cnt);
    end

    for (int t = 0; t < DT; t++) d[t] = 8'h1D * (t + 3) + 8'h5A;
    send_byte(d, 9'h000, 1'b1, 8'h00, "R2");
    send_byte(d, 9'h008, 1'b1, 8'hA5, "R3");
    for (int t = 0; t < DT; t++) d[t] = ~d[t] ^ 8'(t * 17);
    send_byte(d, 9'h001, 1'b1, 8'hFF, "R3");
    send_byte(d, 9'h100, 1'b1, 8'h3C, "R4");
    send_byte(d, 9'h024, 1'b1, 8'h81, "R5");
    send_byte(d, 9'h181, 1'b1, 8'h7E, "R5");
    send_byte(d, 9'h010, 1'b0, 8'hC3, "R6");
    send_byte(d, 9'h000, 1'b0, 8'h00, "R6");
    send_byte(d, 9'h004, 1'b1, 8'h66, "R7");
    // R8: bits after the window pass unchanged
    step(9'h1B7, 1'b0, 1'b1, "R8", 9'h1B7);
    step(9'h0F2, 1'b0, 1'b1, "R8", 9'h0F2);
    step(9'h155, 1'b0, 1'b1, "R8", 9'h155);
    idle(2, "R2");
    // R9: drive repairs past the counter limit
    for (int i = 0; i < 18; i++) begin
      for (int t = 0; t < DT; t++) d[t] = 8'(i * 29 + t * 7);
      send_byte(d, 9'(1 << (i % 9)), 1'b1, 8'(i + 1), "R9");
    end
    send_byte(d, 9'h003, 1'b1, 8'h11, "R9");
    idle(3, "R2");
    repeat (3) @(negedge clk);
    report();
  end
endmodule